// File: doc/BRIEF.md
# Extended Interrupt Routing Controller

The controller takes a wide vector of level-sensitive interrupt inputs and steers each one to an output pin of a processor core. Software programs it through a 32-bit register port. Every access carries the identifier of the requesting core. The interrupts come in groups of 32. Each group is assigned one of a core's output pins through a byte in a pin-map register. Each interrupt is assigned a target core through its own byte in a core-map register. Both kinds of byte are decoded from their lowest set bit, and an encoding that is empty or out of range falls back to entry 0.

An enabled input that becomes pending is delivered to its core. Delivery sets a bit in that core's in-service view. A core pin is high while any delivered interrupt routed to it is still in service. Software acknowledges an interrupt by writing 1 to its bit in the in-service bank. Enabling an input that is already pending delivers it. Disabling a pending input withdraws it. Moving a pending interrupt to another core withdraws it from the old core and raises it on the new one. Bounce and node-type words are plain storage.

Top module: `xirq_router`

## Requirements
- R1: The raw pending bank (word offsets 0x040 upward, bit i%32 of word i/32) reads back the level each input had at the previous clock, whether or not the input is enabled.
- R2: An input whose enable bit (bank at 0x000, same bit layout) is 0 never sets an in-service bit and never raises a pin.
- R3: Pin-map words at 0x080 hold one byte per group, little-endian, so byte k of word w serves group 4w+k. The pin is the index of the byte's lowest set bit, and pin 0 is used when that index is 4 or more or the byte is zero.
- R4: Core-map words at 0x200 hold one byte per interrupt, little-endian, so byte k of word w serves interrupt 4w+k. The byte is decoded the same way as a pin-map byte, with core 0 as the fallback. Output pin p of core c is bit c*4+p of `core_irq`.
- R5: A pin stays high while at least one in-service interrupt routed to it remains, and falls only when the last one goes.
- R6: Setting an enable bit while its input is high delivers the interrupt. Clearing an enable bit while its input is high withdraws it.
- R7: The in-service bank at 0x100 shows and clears only the interrupts owned by the requesting core, and an identifier of 4 or more selects core 0. Writing 1 clears a bit. The bit stays clear while the input stays high, and comes back only on a new delivery: the input falls and rises again, the enable is set again, or the interrupt is remapped.
- R8: Changing a pending interrupt's core-map byte moves its in-service bit and pin from the old core to the new core in the same cycle.
- R9: Bounce words (0x300) and node-type words (0x380) read back what was written and do not affect routing. Other offsets read zero and ignore writes. Address bits above 15 are ignored.
- R10: After reset all registers and pins are zero. A pin changes one clock after the input edge or register write that causes the change, and read data appears one clock after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_IRQ | Level interrupt inputs, synchronous to clk |
| bus_req | input | 1 | Register access valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; bits 15:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_src | input | SRC_W | Identifier of the requesting core |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| core_irq | output | N_CORE*N_PIN | Output pins, core-major |

## Verification
The hardest states to reach are those where routing changes while an interrupt is held pending. Examples are a remap onto another core, an acknowledge from the wrong core, and an acknowledge addressed through an out-of-range identifier. None of these can be set up with the input edge alone. The stimulus first holds an input high with its enable set. It then drives core-map writes one after another: a valid one-hot byte, a byte whose lowest set bit is past the core count, and a byte that changes only the neighbouring interrupt. Acknowledges are issued from a foreign core, from the owning core, and from an identifier of 200. Each step is followed by a check that the pin vector moved exactly one clock later.

// File: rtl/xirq_pkg.sv
// Shared constants and helpers for the interrupt router.
// Word-address bases of each register bank (byte offset / 4).
package xirq_pkg;
    localparam int unsigned W_EN   = 0;    // 0x000 enable masks
    localparam int unsigned W_RAW  = 16;   // 0x040 raw pending (read only)
    localparam int unsigned W_PMAP = 32;   // 0x080 group-to-pin map
    localparam int unsigned W_ISV  = 64;   // 0x100 per-core in-service
    localparam int unsigned W_CMAP = 128;  // 0x200 interrupt-to-core map
    localparam int unsigned W_BNC  = 192;  // 0x300 bounce storage
    localparam int unsigned W_NODE = 224;  // 0x380 node-type storage

    // True when word address w lies in [base, base+cnt).
    function automatic bit in_bank(int unsigned w, int unsigned base, int unsigned cnt);
        return (w >= base) && (w < base + cnt);
    endfunction
endpackage

// File: rtl/xirq_lsb_dec.sv
// Decodes one routing byte to an index: the position of its lowest set
// bit, or 0 when the byte is empty or that position is LIMIT or more.
// Assumes OUT_W bits can hold LIMIT-1.
module xirq_lsb_dec #(
    parameter int OUT_W = 2,
    parameter int LIMIT = 4
) (
    input  logic [7:0]       byte_i,
    output logic [OUT_W-1:0] idx_o
);
    logic found;

    // Scan from bit 0 upward and keep the first hit if it is in range.
    always_comb begin
        idx_o = '0;
        found = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (!found && byte_i[i]) begin
                found = 1'b1;
                if (i < LIMIT) idx_o = OUT_W'(i);
            end
        end
    end
endmodule

// File: rtl/xirq_regs.sv
// Register banks of the router: enables, pin map, core map, bounce and
// node-type storage, plus read mux and acknowledge (write-1-clear) decode.
// Exposes both current (_q) and next (_d) routing so the pin stage can
// register outputs one clock after a write. Assumes N_IRQ <= 256 and a
// multiple of 32.
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int N_IRQ      = 256,
    parameter int N_CORE     = 4,
    parameter int N_PIN      = 4,
    parameter int SRC_W      = 8,
    parameter int NODE_WORDS = 4,
    localparam int N_GRP      = N_IRQ / 32,
    localparam int PMAP_WORDS = (N_GRP + 3) / 4,
    localparam int CMAP_WORDS = N_IRQ / 4,
    localparam int CW         = (N_CORE > 1) ? $clog2(N_CORE) : 1,
    localparam int PW         = (N_PIN > 1) ? $clog2(N_PIN) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic                         we,
    input  logic [13:0]                  waddr,
    input  logic [31:0]                  wdata,
    input  logic [SRC_W-1:0]             src,
    input  logic [N_IRQ-1:0]             raw_q,
    input  logic [N_IRQ-1:0]             insvc_q,
    output logic [31:0]                  rdata,
    output logic [N_IRQ-1:0]             en_q,
    output logic [N_IRQ-1:0]             en_d,
    output logic [N_IRQ-1:0][CW-1:0]     owner_q,
    output logic [N_IRQ-1:0][CW-1:0]     owner_d,
    output logic [N_GRP-1:0][PW-1:0]     pin_d,
    output logic [N_IRQ-1:0]             w1c
);
    logic [N_GRP-1:0][31:0]      en_r,   en_n;
    logic [PMAP_WORDS-1:0][31:0] pmap_r, pmap_n;
    logic [CMAP_WORDS-1:0][31:0] cmap_r, cmap_n;
    logic [N_GRP-1:0][31:0]      bnc_r,  bnc_n;
    logic [NODE_WORDS-1:0][31:0] node_r, node_n;
    logic [31:0]                 rd_n;
    logic [CW-1:0]               req_core;
    int unsigned                 w;
    logic                        wr;

    assign w        = 32'(waddr);
    assign wr       = req && we;
    assign req_core = (src < SRC_W'(N_CORE)) ? src[CW-1:0] : '0;
    assign en_q     = en_r;
    assign en_d     = en_n;

    // Next-state of every writable bank for the current access.
    always_comb begin
        en_n   = en_r;
        pmap_n = pmap_r;
        cmap_n = cmap_r;
        bnc_n  = bnc_r;
        node_n = node_r;
        if (wr) begin
            if (in_bank(w, W_EN, N_GRP))           en_n[w - W_EN]     = wdata;
            if (in_bank(w, W_PMAP, PMAP_WORDS))    pmap_n[w - W_PMAP] = wdata;
            if (in_bank(w, W_CMAP, CMAP_WORDS))    cmap_n[w - W_CMAP] = wdata;
            if (in_bank(w, W_BNC, N_GRP))          bnc_n[w - W_BNC]   = wdata;
            if (in_bank(w, W_NODE, NODE_WORDS))    node_n[w - W_NODE] = wdata;
        end
    end

    // Acknowledge vector: written ones hitting interrupts owned by the requester.
    always_comb begin
        w1c = '0;
        if (wr && in_bank(w, W_ISV, N_GRP)) begin
            for (int i = 0; i < N_IRQ; i++) begin
                if (i / 32 == int'(w - W_ISV) && wdata[i % 32] && owner_q[i] == req_core)
                    w1c[i] = 1'b1;
            end
        end
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        rd_n = '0;
        if (in_bank(w, W_EN, N_GRP))             rd_n = en_r[w - W_EN];
        else if (in_bank(w, W_RAW, N_GRP))       rd_n = raw_q[32*(w - W_RAW) +: 32];
        else if (in_bank(w, W_PMAP, PMAP_WORDS)) rd_n = pmap_r[w - W_PMAP];
        else if (in_bank(w, W_ISV, N_GRP)) begin
            for (int b = 0; b < 32; b++)
                rd_n[b] = insvc_q[32*(w - W_ISV) + b] && (owner_q[32*(w - W_ISV) + b] == req_core);
        end
        else if (in_bank(w, W_CMAP, CMAP_WORDS)) rd_n = cmap_r[w - W_CMAP];
        else if (in_bank(w, W_BNC, N_GRP))       rd_n = bnc_r[w - W_BNC];
        else if (in_bank(w, W_NODE, NODE_WORDS)) rd_n = node_r[w - W_NODE];
    end

    // Bank storage and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_r   <= '0;
            pmap_r <= '0;
            cmap_r <= '0;
            bnc_r  <= '0;
            node_r <= '0;
            rdata  <= '0;
        end else begin
            en_r   <= en_n;
            pmap_r <= pmap_n;
            cmap_r <= cmap_n;
            bnc_r  <= bnc_n;
            node_r <= node_n;
            if (req && !we) rdata <= rd_n;
        end
    end

    // One pin decoder per group, fed by the next pin-map value.
    for (genvar g = 0; g < N_GRP; g++) begin : g_pin
        xirq_lsb_dec #(.OUT_W(PW), .LIMIT(N_PIN)) u_dec (
            .byte_i (pmap_n[g/4][8*(g%4) +: 8]),
            .idx_o  (pin_d[g])
        );
    end

    // Two core decoders per interrupt: current and next owner.
    for (genvar i = 0; i < N_IRQ; i++) begin : g_core
        xirq_lsb_dec #(.OUT_W(CW), .LIMIT(N_CORE)) u_dec_q (
            .byte_i (cmap_r[i/4][8*(i%4) +: 8]),
            .idx_o  (owner_q[i])
        );
        xirq_lsb_dec #(.OUT_W(CW), .LIMIT(N_CORE)) u_dec_d (
            .byte_i (cmap_n[i/4][8*(i%4) +: 8]),
            .idx_o  (owner_d[i])
        );
    end
endmodule

// File: rtl/xirq_track.sv
// Per-interrupt delivery state. Samples input levels (raw pending) and keeps
// one in-service bit per interrupt, owned by the core its map selects.
// A bit is set on a fresh delivery (entering enabled-and-pending, or a
// remap) and cleared by acknowledge, input fall or enable fall.
// Assumes irq_in is synchronous to clk.
module xirq_track #(
    parameter int N_IRQ  = 256,
    parameter int N_CORE = 4,
    localparam int CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IRQ-1:0]         irq_in,
    input  logic [N_IRQ-1:0]         en_q,
    input  logic [N_IRQ-1:0]         en_d,
    input  logic [N_IRQ-1:0][CW-1:0] owner_q,
    input  logic [N_IRQ-1:0][CW-1:0] owner_d,
    input  logic [N_IRQ-1:0]         w1c,
    output logic [N_IRQ-1:0]         raw_q,
    output logic [N_IRQ-1:0]         insvc_q,
    output logic [N_IRQ-1:0]         insvc_d
);
    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        logic fresh;
        // A delivery is new unless the interrupt was already live on the same core.
        assign fresh      = !(en_q[i] && raw_q[i]) || (owner_d[i] != owner_q[i]);
        // Next in-service value for this interrupt.
        assign insvc_d[i] = en_d[i] && irq_in[i] && (insvc_q[i] || fresh) && !w1c[i];
    end

    // Level sampling and in-service storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q   <= '0;
            insvc_q <= '0;
        end else begin
            raw_q   <= irq_in;
            insvc_q <= insvc_d;
        end
    end
endmodule

// File: rtl/xirq_pins.sv
// Folds next-cycle in-service bits onto core pins through the next-cycle
// routing and registers the result. Pin p of core c is bit c*N_PIN+p.
module xirq_pins #(
    parameter int N_IRQ  = 256,
    parameter int N_CORE = 4,
    parameter int N_PIN  = 4,
    localparam int N_GRP = N_IRQ / 32,
    localparam int CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1,
    localparam int PW    = (N_PIN > 1) ? $clog2(N_PIN) : 1,
    localparam int N_OUT = N_CORE * N_PIN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IRQ-1:0]         insvc_d,
    input  logic [N_IRQ-1:0][CW-1:0] owner_d,
    input  logic [N_GRP-1:0][PW-1:0] pin_d,
    output logic [N_OUT-1:0]         pins_q
);
    logic [N_OUT-1:0] hit;

    // OR each live interrupt into its target core/pin slot.
    always_comb begin
        hit = '0;
        for (int i = 0; i < N_IRQ; i++)
            hit[int'(owner_d[i]) * N_PIN + int'(pin_d[i/32])] |= insvc_d[i];
    end

    // Registered output pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= hit;
    end
endmodule

// File: rtl/xirq_router.sv
// Top of the interrupt router: register banks, per-interrupt delivery
// tracking and registered pin aggregation. Only address bits 15:2 are
// decoded; accesses are whole 32-bit words.
module xirq_router #(
    parameter int N_IRQ  = 256,
    parameter int N_CORE = 4,
    parameter int N_PIN  = 4,
    parameter int SRC_W  = 8,
    localparam int N_GRP = N_IRQ / 32,
    localparam int CW    = (N_CORE > 1) ? $clog2(N_CORE) : 1,
    localparam int PW    = (N_PIN > 1) ? $clog2(N_PIN) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IRQ-1:0]          irq_in,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [31:0]               bus_addr,
    input  logic [31:0]               bus_wdata,
    input  logic [SRC_W-1:0]          bus_src,
    output logic [31:0]               bus_rdata,
    output logic [N_CORE*N_PIN-1:0]   core_irq
);
    logic [N_IRQ-1:0]         en_q, en_d, raw_q, insvc_q, insvc_d, w1c;
    logic [N_IRQ-1:0][CW-1:0] owner_q, owner_d;
    logic [N_GRP-1:0][PW-1:0] pin_d;
    logic [17:0]              unused_addr_bits;

    assign unused_addr_bits = {bus_addr[31:16], bus_addr[1:0]};

    xirq_regs #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_PIN(N_PIN), .SRC_W(SRC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .we      (bus_we),
        .waddr   (bus_addr[15:2]),
        .wdata   (bus_wdata),
        .src     (bus_src),
        .raw_q   (raw_q),
        .insvc_q (insvc_q),
        .rdata   (bus_rdata),
        .en_q    (en_q),
        .en_d    (en_d),
        .owner_q (owner_q),
        .owner_d (owner_d),
        .pin_d   (pin_d),
        .w1c     (w1c)
    );

    xirq_track #(.N_IRQ(N_IRQ), .N_CORE(N_CORE)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .en_q    (en_q),
        .en_d    (en_d),
        .owner_q (owner_q),
        .owner_d (owner_d),
        .w1c     (w1c),
        .raw_q   (raw_q),
        .insvc_q (insvc_q),
        .insvc_d (insvc_d)
    );

    xirq_pins #(.N_IRQ(N_IRQ), .N_CORE(N_CORE), .N_PIN(N_PIN)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .insvc_d (insvc_d),
        .owner_d (owner_d),
        .pin_d   (pin_d),
        .pins_q  (core_irq)
    );
endmodule

// File: rtl/xirq_router_chk.sv
// Property checker for xirq_router, attached by bind below.
module xirq_router_chk #(
    parameter int N_IRQ = 256,
    parameter int N_OUT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [5:0]        addr_hi,
    input logic [31:0]       bus_rdata,
    input logic [N_OUT-1:0]  core_irq,
    input logic [N_IRQ-1:0]  en_q,
    input logic [N_IRQ-1:0]  raw_q,
    input logic [N_IRQ-1:0]  insvc_q
);
    // R2
    insvc_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_q & ~(en_q & raw_q)) == '0);

    // R2
    quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> (core_irq == '0));

    // R5
    pin_needs_insvc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq != '0) |-> (insvc_q != '0));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && addr_hi != 6'd0) |=> (bus_rdata == 32'd0));

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (core_irq == '0 && bus_rdata == 32'd0));
endmodule

bind xirq_router xirq_router_chk #(.N_IRQ(N_IRQ), .N_OUT(N_CORE*N_PIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .addr_hi   (bus_addr[15:10]),
    .bus_rdata (bus_rdata),
    .core_irq  (core_irq),
    .en_q      (en_q),
    .raw_q     (raw_q),
    .insvc_q   (insvc_q)
);

// File: tb/xirq_router_bench.sv
// Scoreboard bench: driver tasks queue expected pin vectors and read data
// with the cycle they are due; a monitor compares them after each edge.
module xirq_router_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] irq_in = '0;
    logic         bus_req = 1'b0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [7:0]   bus_src = '0;
    logic [31:0]  bus_rdata;
    logic [15:0]  core_irq;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    xirq_router u_xirq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_src   (bus_src),
        .bus_rdata (bus_rdata),
        .core_irq  (core_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input bit is_rd, input logic [31:0] exp, input string tag);
        item_t it;
        it.due = cyc + 1; it.is_rd = is_rd; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic drive(input bit req, input bit we, input logic [31:0] a,
                         input logic [31:0] d, input logic [7:0] s);
        @(negedge clk);
        bus_req = req; bus_we = we; bus_addr = a; bus_wdata = d; bus_src = s;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [7:0] s);
        drive(1'b1, 1'b1, a, d, s);
    endtask

    task automatic rd(input logic [31:0] a, input logic [7:0] s,
                      input logic [31:0] exp, input string tag);
        drive(1'b1, 1'b0, a, 32'd0, s);
        push(1'b1, exp, tag);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 32'd0, 32'd0, 8'd0);
    endtask

    task automatic set_irq(input int idx, input logic v);
        @(negedge clk);
        bus_req = 1'b0;
        irq_in[idx] = v;
    endtask

    task automatic exp_pins(input logic [15:0] v, input string tag);
        push(1'b0, {16'd0, v}, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Monitor: compare due items a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                act = it.is_rd ? bus_rdata : {16'd0, core_irq};
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();                     exp_pins(16'h0000, "R10 reset pins");
        rd(32'h000, 0, 32'h0, "R10 reset enable");

        // R1 / R2: disabled input is recorded but not delivered
        set_irq(5, 1'b1);           exp_pins(16'h0000, "R2 disabled input");
        rd(32'h040, 0, 32'h20, "R1 raw pending");
        rd(32'h100, 0, 32'h0, "R2 no in-service");

        // R6: enable rise with pending input delivers
        wr(32'h000, 32'h20, 0);     exp_pins(16'h0001, "R6 enable rise delivers");
        rd(32'h100, 0, 32'h20, "R7 owner view");
        rd(32'h100, 1, 32'h0, "R7 foreign view");

        // R7: acknowledge
        wr(32'h100, 32'h20, 1);     exp_pins(16'h0001, "R7 foreign ack ignored");
        wr(32'h100, 32'h20, 0);     exp_pins(16'h0000, "R7 ack clears");
        idle();                     exp_pins(16'h0000, "R7 stays clear while high");
        rd(32'h100, 0, 32'h0, "R7 bit cleared");
        set_irq(5, 1'b0);           exp_pins(16'h0000, "R7 input low");
        set_irq(5, 1'b1);           exp_pins(16'h0001, "R10 one clock after input edge");

        // R6: enable fall withdraws, rise redelivers
        wr(32'h000, 32'h0, 0);      exp_pins(16'h0000, "R6 enable fall withdraws");
        wr(32'h000, 32'h20, 0);     exp_pins(16'h0001, "R6 re-enable");

        // R5: shared pin
        wr(32'h000, 32'hA0, 0);     exp_pins(16'h0001, "R5 second enable");
        set_irq(7, 1'b1);           exp_pins(16'h0001, "R5 two live");
        set_irq(5, 1'b0);           exp_pins(16'h0001, "R5 one remains");
        set_irq(7, 1'b0);           exp_pins(16'h0000, "R5 last clears");

        // R3: pin map decode
        wr(32'h080, 32'h04, 0);     exp_pins(16'h0000, "R3 map idle");
        set_irq(7, 1'b1);           exp_pins(16'h0004, "R3 bit2 selects pin2");
        wr(32'h080, 32'h10, 0);     exp_pins(16'h0001, "R3 index 4 falls back");
        wr(32'h080, 32'h00, 0);     exp_pins(16'h0001, "R3 zero byte falls back");
        wr(32'h080, 32'h0C, 0);     exp_pins(16'h0004, "R3 lowest bit wins");
        set_irq(7, 1'b0);           exp_pins(16'h0000, "R3 drop");
        wr(32'h080, 32'h0800, 0);   exp_pins(16'h0000, "R3 byte1 write");
        wr(32'h004, 32'h100, 0);    exp_pins(16'h0000, "R3 enable irq40");
        set_irq(40, 1'b1);          exp_pins(16'h0008, "R3 group1 pin3");

        // R4 / R8: core map and live remap
        wr(32'h228, 32'h02, 0);     exp_pins(16'h0080, "R8 remap to core1");
        wr(32'h228, 32'h20, 0);     exp_pins(16'h0008, "R4 out-of-range core falls back");
        wr(32'h228, 32'h04, 0);     exp_pins(16'h0800, "R4 core2");
        wr(32'h228, 32'h0804, 0);   exp_pins(16'h0800, "R4 neighbour byte only");

        // R9: inert storage and unmapped space
        wr(32'h300, 32'hDEADBEEF, 0); exp_pins(16'h0800, "R9 bounce no effect");
        wr(32'h384, 32'h1234, 0);   exp_pins(16'h0800, "R9 node-type no effect");
        rd(32'h300, 0, 32'hDEADBEEF, "R9 bounce readback");
        rd(32'h384, 0, 32'h1234, "R9 node-type readback");
        rd(32'hABCD0300, 0, 32'hDEADBEEF, "R9 upper address ignored");
        wr(32'h500, 32'hFFFFFFFF, 0); exp_pins(16'h0800, "R9 unmapped write");
        rd(32'h500, 0, 32'h0, "R9 unmapped read");

        // R8 back to core0, R7 out-of-range requester
        wr(32'h228, 32'h0801, 0);   exp_pins(16'h0008, "R8 remap to core0");
        rd(32'h104, 200, 32'h100, "R7 wide id reads core0");
        wr(32'h104, 32'h100, 200);  exp_pins(16'h0000, "R7 wide id ack");
        idle();
        repeat (3) idle();
        done = 1'b1;
        summary();
    end
endmodule